// File: doc/BRIEF.md
# Password-Gated Bank Write Lock

This block guards register writes into a peripheral that is split into several banks. Each bank carries one bit of lock state, and the block drives one write-permit line per bank. The bank's own register logic uses that line to drop writes while the bank is locked. Reads are never blocked.

Changing a bank's lock state takes two bus writes in a row. First the master writes the key value 0x00A5A501 to the key register at offset 0x520. The very next bus write, if it goes to that bank's lock-status word, then takes effect. Writing all ones closes the bank and writing all zeros opens it. Any other write in between uses up the key, and so does a wrong value. Every bank starts locked after reset. A read of a lock-status word returns the code that matches the bank's current state.

Top module: `bank_lock_guard`

## Requirements
- R1: While reset is high and after it is released, every bank is locked: `bank_wr_permit` is all zeros and a read of any lock-status word returns 0xFFFFFFFF.
- R2: A write of 0x00A5A501 to address 0x520 arms the key. If the next write is 0x00000000 to the lock-status word of bank b, at address 0x500 + 4*b, bank b opens and `bank_wr_permit[b]` is high from the clock edge that takes that write.
- R3: An armed write of 0xFFFFFFFF to the lock-status word of bank b locks bank b, and `bank_wr_permit[b]` goes low from that edge.
- R4: A lock-status write made while the key is not armed leaves every bank's lock state unchanged.
- R5: Any write other than a correct key write disarms the key, including a write of a wrong value to 0x520. Cycles with `bus_we` low do not disarm it.
- R6: An armed lock-status write whose value is neither 0x00000000 nor 0xFFFFFFFF leaves the lock state unchanged and still uses up the key.
- R7: A lock-status write changes only the bank it addresses. Writes to addresses that are not the word-aligned lock-status words of existing banks change no bank.
- R8: Read data is registered. In the cycle after an address is presented, `bus_rdata` is 0xFFFFFFFF if that address is the lock-status word of a locked bank, and 0x00000000 for an open bank or for any other address.
- R9: One key write allows exactly one lock-status write. A second lock-status write that follows without a new key write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable; low means read |
| bus_rdata | output | 32 | Registered read data |
| bank_wr_permit | output | NUM_BANKS (8) | High while the bank is open for writes |

## Verification
The hard case to reach from the ports is the key being armed at the moment a disruptive access arrives. Examples are a stray write, a wrong key, a read-only cycle, an out-of-range code, or a second lock write after the key has already been used. A random stream of accesses would rarely line these up. The directed part of the stimulus therefore sends a key write and then each kind of follow-up access straight after it. A weighted random stream then mixes key writes, lock writes and reads across all banks, and a behavioural model is compared against the design on every cycle.

// File: rtl/bank_lock_pkg.sv
package bank_lock_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] ARM_KEY   = 32'h00A5_A501;
  localparam logic [WORD_W-1:0] CODE_SHUT = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] CODE_OPEN = 32'h0000_0000;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_SHUT = 2'd1,
    CMD_OPEN = 2'd2
  } lock_cmd_e;
endpackage

// File: rtl/key_arm.sv
module key_arm
  import bank_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h520
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              armed_o
);
  logic key_hit;
  assign key_hit = (addr_i == KEY_ADDR) && (wdata_i == ARM_KEY);

  // Every write reloads the arm bit; idle/read cycles keep it.
  always_ff @(posedge clk) begin
    if (rst) armed_o <= 1'b0;
    else if (we_i) armed_o <= key_hit;
  end

  // R2: arm is only ever set by a correct key write
  p_arm_from_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_o) |-> $past(we_i && addr_i == KEY_ADDR && wdata_i == ARM_KEY));

  // R5 / R9: any other write consumes the key
  p_arm_consumed_r5: assert property (@(posedge clk) disable iff (rst)
    (we_i && !(addr_i == KEY_ADDR && wdata_i == ARM_KEY)) |=> !armed_o);

  // R5: read cycles keep the arm state
  p_read_keeps_arm_r5: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(armed_o));
endmodule

// File: rtl/bank_lock_cell.sv
module bank_lock_cell
  import bank_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sel_i,
  input  lock_cmd_e cmd_i,
  output logic      open_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
    end else if (sel_i) begin
      case (cmd_i)
        CMD_SHUT: open_o <= 1'b0;
        CMD_OPEN: open_o <= 1'b1;
        default:  open_o <= open_o;
      endcase
    end
  end

  // R7: a bank not addressed keeps its state
  p_hold_unselected_r7: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> $stable(open_o));

  // R6: no command means no change even when addressed
  p_no_cmd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_NONE) |=> $stable(open_o));
endmodule

// File: rtl/lock_readback.sv
module lock_readback
  import bank_lock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] sel_i,
  input  logic [NUM_BANKS-1:0] open_i,
  output logic [WORD_W-1:0]    rdata_o
);
  logic hit_shut;
  assign hit_shut = |(sel_i & ~open_i);

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= hit_shut ? CODE_SHUT : CODE_OPEN;
  end

  // R8: a selected locked bank reads back the lock code a cycle later
  p_read_shut_code_r8: assert property (@(posedge clk) disable iff (rst)
    hit_shut |=> rdata_o == CODE_SHUT);

  // R8: no selected locked bank reads back zero
  p_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !hit_shut |=> rdata_o == CODE_OPEN);
endmodule

// File: rtl/bank_lock_guard.sv
module bank_lock_guard
  import bank_lock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h520,
  parameter logic [ADDR_W-1:0] STAT_BASE = 12'h500
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  output logic [31:0]          bus_rdata,
  output logic [NUM_BANKS-1:0] bank_wr_permit
);
  localparam int unsigned WORD_BYTES = WORD_W / 8;

  logic                 armed;
  logic [NUM_BANKS-1:0] bank_sel;
  lock_cmd_e            cmd;

  key_arm #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_arm (
    .clk(clk), .rst(rst), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .armed_o(armed)
  );

  always_comb begin
    cmd = CMD_NONE;
    if (bus_we && armed) begin
      if (bus_wdata == CODE_SHUT)      cmd = CMD_SHUT;
      else if (bus_wdata == CODE_OPEN) cmd = CMD_OPEN;
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bank_sel[i] = (bus_addr == STAT_BASE + ADDR_W'(WORD_BYTES * i));
    bank_lock_cell u_cell (
      .clk(clk), .rst(rst), .sel_i(bank_sel[i]), .cmd_i(cmd),
      .open_o(bank_wr_permit[i])
    );
  end

  lock_readback #(.NUM_BANKS(NUM_BANKS)) u_rd (
    .clk(clk), .rst(rst), .sel_i(bank_sel), .open_i(bank_wr_permit),
    .rdata_o(bus_rdata)
  );

  // R1: banks are all locked right after reset
  p_reset_locked_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> bank_wr_permit == '0);

  // R4: without an armed key no permit changes
  p_unarmed_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !armed |=> $stable(bank_wr_permit));

  // R7: at most one bank changes per cycle
  p_single_bank_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_wr_permit ^ $past(bank_wr_permit)));

  // R2: a bank can only open on an armed write
  p_open_needs_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (|(bank_wr_permit & ~$past(bank_wr_permit))) |-> $past(armed && bus_we));
endmodule

// File: tb/bank_lock_guard_test.sv
module bank_lock_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] KEYA = 12'h520;
  localparam logic [31:0] KEYV = 32'h00A5A501;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  permit;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  bank_lock_guard uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .bank_wr_permit(permit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [7:0]  m_open;
  logic        m_armed;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [11:0] a, input logic [7:0] op);
    m_read = 32'h0;
    for (int k = 0; k < 8; k++)
      if (a == 12'h500 + 12'(4*k) && !op[k]) m_read = 32'hFFFFFFFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_open <= '0; m_armed <= 1'b0; m_rdata <= '0;
    end else begin
      m_rdata <= m_read(addr, m_open);
      if (we) begin
        m_armed <= (addr == KEYA && wdata == KEYV);
        if (m_armed)
          for (int k = 0; k < 8; k++)
            if (addr == 12'h500 + 12'(4*k)) begin
              if (wdata == 32'h0) m_open[k] <= 1'b1;
              else if (wdata == 32'hFFFFFFFF) m_open[k] <= 1'b0;
            end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({24'h0, permit}, {24'h0, m_open}, {cur_req, " permit vs model"});
      chk(rdata, m_rdata, {cur_req, " rdata vs model"});
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
  endtask
  task automatic idle();
    @(negedge clk); addr = 12'h0; wdata = '0; we = 1'b0;
  endtask
  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); chk(rdata, exp, tag);
  endtask
  function automatic logic [11:0] sa(input int b);
    sa = 12'h500 + 12'(4*b);
  endfunction

  task automatic report();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({24'h0, permit}, 32'h0, "R1 permit in reset");
    rst = 1'b0;
    @(negedge clk);
    chk({24'h0, permit}, 32'h0, "R1 permit after reset");
    bus_rd(sa(2), 32'hFFFFFFFF, "R1 lock readback");

    cur_req = "R2";
    bus_wr(KEYA, KEYV); bus_wr(sa(3), 32'h0); idle();
    chk({24'h0, permit}, 32'h08, "R2 open bank 3");
    cur_req = "R8";
    bus_rd(sa(3), 32'h0, "R8 open readback");
    bus_rd(12'h100, 32'h0, "R8 other address");

    cur_req = "R3";
    bus_wr(KEYA, KEYV); bus_wr(sa(3), 32'hFFFFFFFF); idle();
    chk({24'h0, permit}, 32'h00, "R3 lock bank 3");

    cur_req = "R4";
    bus_wr(sa(5), 32'h0); idle();
    chk({24'h0, permit}, 32'h00, "R4 unarmed write");

    cur_req = "R5";
    bus_wr(KEYA, KEYV); bus_wr(12'h100, 32'h1); bus_wr(sa(5), 32'h0); idle();
    chk({24'h0, permit}, 32'h00, "R5 stray write disarms");
    bus_wr(KEYA, 32'h00A5A500); bus_wr(sa(5), 32'h0); idle();
    chk({24'h0, permit}, 32'h00, "R5 wrong key");
    bus_wr(KEYA, KEYV); idle(); idle(); bus_wr(sa(5), 32'h0); idle();
    chk({24'h0, permit}, 32'h20, "R5 reads keep arm");

    cur_req = "R6";
    bus_wr(KEYA, KEYV); bus_wr(sa(6), 32'h12345678); bus_wr(sa(6), 32'h0); idle();
    chk({24'h0, permit}, 32'h20, "R6 bad code ignored and consumed");

    cur_req = "R9";
    bus_wr(KEYA, KEYV); bus_wr(sa(1), 32'h0); bus_wr(sa(2), 32'h0); idle();
    chk({24'h0, permit}, 32'h22, "R9 single use key");

    cur_req = "R7";
    bus_wr(KEYA, KEYV); bus_wr(12'h501, 32'h0); idle();
    chk({24'h0, permit}, 32'h22, "R7 unaligned address");
    bus_wr(KEYA, KEYV); bus_wr(sa(7), 32'h0); idle();
    chk({24'h0, permit}, 32'hA2, "R7 only bank 7 opens");
    bus_rd(sa(0), 32'hFFFFFFFF, "R7 bank 0 still locked");
    bus_rd(sa(1), 32'h0, "R7 bank 1 still open");

    cur_req = "R2 R3 R8 random";
    for (int n = 0; n < 2000; n++) begin
      int op = $urandom_range(0, 9);
      int b  = $urandom_range(0, 7);
      case (op)
        0, 1, 2: bus_wr(KEYA, KEYV);
        3, 4: bus_wr(sa(b), $urandom_range(0, 1) ? 32'h0 : 32'hFFFFFFFF);
        5: bus_wr(sa(b), 32'h0000_0100);
        6: bus_wr(KEYA, $urandom);
        7: begin @(negedge clk); addr = sa(b); we = 1'b0; end
        8: bus_wr(12'h004, 32'h0);
        default: idle();
      endcase
    end
    idle(); idle();
    report();
  end
endmodule